// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is a clock-driven model of a single-ported burst memory with per-byte write control. Words are four 9-bit bytes wide, and the number of words is set by a parameter. Three enable inputs together decide whether the part is selected. While it is selected, a low level on either of two address strobes captures a new word address. The two low address bits go into a two-bit burst counter, and an advance input steps that counter from cycle to cycle. The upper address bits do not change during a burst.

From the moment an address is captured, every clock cycle is an access cycle until a deselect happens. Each access cycle is a write if the global write or a byte write is active. Otherwise it is a read. Read data is registered and shows up one clock after its access cycle. An asynchronous output enable gates the read data. The tri-state data port is split into separate input, output and output-valid signals, so the high-impedance state can be seen directly. The first read after a deselected period, or after reset, is always held off the port.

Top module: `burst_sram_ctl`

## Requirements
- R1: The part is selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. A qualified strobe that arrives while the part is not selected ends the burst. Such a cycle loads no address, writes nothing, and the following cycles without a new load are not accesses (`dvalid` stays 0).
- R2: A low `strobe_c_n` or `strobe_p_n` while the part is selected captures `addr`, and that cycle is an access at `addr`. When `en1_n` is high, `strobe_p_n` has no effect at all: no load and no deselect, and a running burst continues at its counter address.
- R3: When both strobes are low and the part is selected, the processor strobe takes the request, and `addr` is loaded exactly once.
- R4: In a burst, a cycle with `adv_n`=0 increments the two low address bits before the access. The count is linear and wraps from 3 to 0 while the upper bits stay fixed. A cycle with `adv_n`=1 accesses the same address again.
- R5: `gwe_n`=0 writes all four bytes of the word (byte i is `din[9i+8:9i]`), whatever `bwe_n` and `bsel_n` are.
- R6: With `gwe_n`=1 and `bwe_n`=0, each `bsel_n[i]`=0 writes byte i and leaves the other bytes unchanged. If no byte is selected, or if `bwe_n`=1, the access is a read and `din` is ignored.
- R7: A read returns the word at its access address on `dout`, with `dvalid`=1, after the next rising edge, provided `oe_n`=0. `oe_n`=1 forces `dvalid`=0 and `dout`=0 at once, without waiting for a clock edge.
- R8: A read whose address was loaded while no burst was active (after a deselect or after reset) never reaches the port: `dvalid` stays 0 for that read.
- R9: During reset and after it, `dvalid` is 0, no burst is active, and no access takes place until a strobe loads an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Enable 1, active low |
| en2 | input | 1 | Enable 2, active high |
| en3_n | input | 1 | Enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | NBYTES*BYTE_W | Write data |
| dout | output | NBYTES*BYTE_W | Read data, zero while not driven |
| dvalid | output | 1 | High when the port would drive read data |

## Verification
The main function is exercised with a four-beat write burst followed by a read burst that wraps past address 3. This shows whether the count is linear and whether the upper bits stay fixed. Advance-held cycles separate re-access from increment. Global writes with an all-high byte mask, partial byte masks, and a byte-write enable with no byte selected separate override, merge and read-fallback behaviour. Processor strobes with enable 1 high, strobes issued with each enable wrong in turn, and reads loaded from the idle state separate an ignored request from a deselect and from output masking.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // linear two-bit burst step, wraps 3 -> 0
  function automatic logic [1:0] burst_step(input logic [1:0] cnt, input logic adv_n);
    return adv_n ? cnt : cnt + 2'd1;
  endfunction

endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              adv_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              access,
  output logic              from_idle
);
  import burst_sram_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic            active_q, active_d;
  logic [HI_W-1:0] base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            sel, p_req, c_req, req, load, desel;

  always_comb begin
    sel   = !en1_n && en2 && !en3_n;
    p_req = !strobe_p_n && !en1_n;   // processor strobe needs enable 1
    c_req = !strobe_c_n;
    req   = p_req || c_req;          // processor request wins; same address
    load  = req && sel;
    desel = req && !sel;
    access    = load || (active_q && !desel);
    from_idle = load && !active_q;
    acc_addr  = load ? addr : {base_q, burst_step(cnt_q, adv_n)};
    active_d  = load ? 1'b1 : (desel ? 1'b0 : active_q);
    base_d    = access ? acc_addr[ADDR_W-1:2] : base_q;
    cnt_d     = access ? acc_addr[1:0] : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !req && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !req && adv_n) |=> $stable(cnt_q)); // R4
  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req) |=> $stable(base_q)); // R4
  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !active_q); // R1
  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_q == $past(addr[ADDR_W-1:2]))); // R2

endmodule

// File: rtl/burst_wr_decode.sv
module burst_wr_decode #(
  parameter int NBYTES = 4
) (
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bsel_n,
  output logic [NBYTES-1:0] wmask
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    // global write overrides the per-byte selects
    assign wmask[b] = !gwe_n || (!bwe_n && !bsel_n[b]);
  end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     access,
  input  logic                     from_idle,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [NBYTES-1:0]        wmask,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] rd_data,
  output logic                     rd_vld,
  output logic                     rd_first
);
  import burst_sram_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  acc_kind_e kind;
  logic      rd_en;
  logic      rd_vld_q, rd_vld_d, rd_first_q, rd_first_d;

  always_comb begin
    if (!access)      kind = ACC_NONE;
    else if (|wmask)  kind = ACC_WRITE;
    else              kind = ACC_READ;
    rd_en      = (kind == ACC_READ);
    rd_vld_d   = rd_en;
    rd_first_d = rd_en && from_idle;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;
    logic              wr_en;

    assign wr_en = (kind == ACC_WRITE) && wmask[b];

    always_ff @(posedge clk) begin
      if (wr_en) mem[acc_addr] <= din[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[acc_addr];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q   <= 1'b0;
      rd_first_q <= 1'b0;
    end else begin
      rd_vld_q   <= rd_vld_d;
      rd_first_q <= rd_first_d;
    end
  end

  assign rd_vld   = rd_vld_q;
  assign rd_first = rd_first_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (wmask == '0)) |=> rd_vld); // R7
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (|wmask)) |=> !rd_vld); // R6
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!access) |=> !rd_vld); // R1

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     strobe_p_n,
  input  logic                     strobe_c_n,
  input  logic                     en1_n,
  input  logic                     en2,
  input  logic                     en3_n,
  input  logic                     adv_n,
  input  logic                     gwe_n,
  input  logic                     bwe_n,
  input  logic [NBYTES-1:0]        bsel_n,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dvalid
);

  localparam int WORD_W = NBYTES * BYTE_W;

  logic              rst_meta, rst_q;
  logic [ADDR_W-1:0] acc_addr;
  logic              access, from_idle;
  logic [NBYTES-1:0] wmask;
  logic [WORD_W-1:0] rd_data;
  logic              rd_vld, rd_first;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  burst_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_q), .addr(addr),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .adv_n(adv_n),
    .acc_addr(acc_addr), .access(access), .from_idle(from_idle)
  );

  burst_wr_decode #(.NBYTES(NBYTES)) u_dec (
    .gwe_n(gwe_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wmask(wmask)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mem (
    .clk(clk), .rst_n(rst_q), .access(access), .from_idle(from_idle),
    .acc_addr(acc_addr), .wmask(wmask), .din(din),
    .rd_data(rd_data), .rd_vld(rd_vld), .rd_first(rd_first)
  );

  // asynchronous output gate; the first read out of idle is held back
  always_comb begin
    dvalid = rd_vld && !rd_first && !oe_n;
    dout   = dvalid ? rd_data : '0;
  end

  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_q)
    oe_n |-> (dout == '0)); // R7
  AST_FIRST_MASKED: assert property (@(posedge clk) disable iff (!rst_q)
    (from_idle && access && (wmask == '0)) |=> !dvalid); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_q) |-> !dvalid); // R9

endmodule

// File: tb/burst_sram_ctl_bench.sv
module burst_sram_ctl_bench;

  localparam logic [35:0] A  = 36'hA5A5A5A5A;
  localparam logic [35:0] B  = 36'h3C3C3C3C3;
  localparam logic [35:0] C  = 36'h0F0F0F0F0;
  localparam logic [35:0] D  = 36'h123456789;
  localparam logic [35:0] F  = 36'hFFFFFFFFF;
  localparam logic [35:0] E  = 36'h0AAAAAAAA;
  localparam logic [35:0] G  = 36'h5A5A5A5A5;
  localparam logic [35:0] M02 = 36'h007FC01FF;   // bytes 0 and 2
  localparam logic [35:0] BM = (B & ~M02) | (F & M02);
  localparam logic [35:0] X  = 36'h111111111;
  localparam logic [35:0] Y  = 36'h222222222;

  typedef struct packed {
    logic [3:0]  req;
    logic        sp, sc, e1, e2, e3, adv, gw, bwe;
    logic [3:0]  bs;
    logic        oe;
    logic [7:0]  addr;
    logic [35:0] din;
    logic        ev;
    logic [35:0] ed;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    // R5 global-write burst 0x10..0x13
    '{4'd5, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 4'hF,1'b0, 8'h10, A, 1'b0, 36'h0},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 4'hF,1'b0, 8'h00, B, 1'b0, 36'h0},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 4'hF,1'b0, 8'h00, C, 1'b0, 36'h0},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 4'hF,1'b0, 8'h00, D, 1'b0, 36'h0},
    // R4 wrap 3->0, R7 read latency
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, A},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, A},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, B},
    '{4'd7, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1, 4'hF,1'b1, 8'h00, 36'h0, 1'b0, 36'h0},
    // R6 byte write of bytes 0 and 2 at 0x11
    '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 4'hA,1'b0, 8'h11, F, 1'b0, 36'h0},
    '{4'd6, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, BM},
    // R1 deselect by en2, R8 masked first read, R4 wrap
    '{4'd1, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h13, 36'h0, 1'b0, 36'h0},
    '{4'd8, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h13, 36'h0, 1'b0, 36'h0},
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, A},
    // R2 processor strobe ignored with en1_n high
    '{4'd2, 1'b0,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h12, 36'h0, 1'b1, A},
    // R3 both strobes
    '{4'd3, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 4'hF,1'b0, 8'h12, E, 1'b0, 36'h0},
    '{4'd3, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, E},
    // R5 global write overrides unselected bytes
    '{4'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'hF,1'b0, 8'h00, G, 1'b0, 36'h0},
    '{4'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, G},
    // R6 no byte selected / bwe high -> read
    '{4'd6, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 4'hF,1'b0, 8'h00, 36'h0, 1'b1, G},
    '{4'd6, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 4'h0,1'b0, 8'h00, 36'h0, 1'b1, G}
  };

  logic        clk, rst_n;
  logic [7:0]  addr;
  logic        strobe_p_n, strobe_c_n, en1_n, en2, en3_n, adv_n, gwe_n, bwe_n, oe_n;
  logic [3:0]  bsel_n;
  logic [35:0] din, dout;
  logic        dvalid;
  int          checks, errors;
  bit          done;

  burst_sram_ctl u_burst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dvalid(dvalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string tag, input logic ev, input logic [35:0] ed);
    checks++;
    if (dvalid !== ev || dout !== ed) begin
      errors++;
      $display("FAIL %s: dvalid=%0b dout=%h expected dvalid=%0b dout=%h",
               tag, dvalid, dout, ev, ed);
    end
  endtask

  task automatic apply(input vec_t v);
    strobe_p_n = v.sp; strobe_c_n = v.sc;
    en1_n = v.e1; en2 = v.e2; en3_n = v.e3; adv_n = v.adv;
    gwe_n = v.gw; bwe_n = v.bwe; bsel_n = v.bs; oe_n = v.oe;
    addr = v.addr; din = v.din;
    @(posedge clk);
    #1;
  endtask

  function automatic vec_t mk(input logic sp, sc, e1, e2, e3, adv, gw, bwe,
                              input logic [7:0] a, input logic [35:0] d);
    vec_t v;
    v = '0;
    v.sp = sp; v.sc = sc; v.e1 = e1; v.e2 = e2; v.e3 = e3;
    v.adv = adv; v.gw = gw; v.bwe = bwe; v.bs = 4'hF; v.oe = 1'b0;
    v.addr = a; v.din = d;
    return v;
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    apply(mk(1,1,0,1,0,1,1,1,8'h00,36'h0));
    chk("R9 reset state", 1'b0, 36'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      chk($sformatf("R%0d table row %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed);
    end

    // R7 output enable acts without a clock edge
    oe_n = 1'b1; #1;
    chk("R7 oe high hides data", 1'b0, 36'h0);
    oe_n = 1'b0; #1;
    chk("R7 oe low shows data", 1'b1, G);

    // R1 each wrong enable in turn
    apply(mk(1,0,0,1,0,1,0,1,8'h20,X));
    chk("R1 setup write", 1'b0, 36'h0);
    for (int k = 0; k < 3; k++) begin
      vec_t v;
      v = mk(1,0,0,1,0,1,0,1,8'h20,Y);
      if (k == 0) v.e1 = 1'b1;
      if (k == 1) v.e2 = 1'b0;
      if (k == 2) v.e3 = 1'b1;
      apply(v);
      chk($sformatf("R1 deselect combo %0d", k), 1'b0, 36'h0);
      apply(mk(1,1,0,1,0,0,1,1,8'h00,36'h0));
      chk($sformatf("R1 no access after deselect %0d", k), 1'b0, 36'h0);
      apply(mk(1,0,0,1,0,1,1,1,8'h20,36'h0));
      chk($sformatf("R8 first read masked %0d", k), 1'b0, 36'h0);
      apply(mk(1,1,0,1,0,1,1,1,8'h00,36'h0));
      chk($sformatf("R1 write blocked %0d", k), 1'b1, X);
    end

    // R9 reset mid-burst
    rst_n = 1'b0; #1;
    chk("R9 reset clears output", 1'b0, 36'h0);
    apply(mk(1,1,0,1,0,1,1,1,8'h00,36'h0));
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    apply(mk(1,1,0,1,0,0,1,1,8'h00,36'h0));
    chk("R9 no burst after reset", 1'b0, 36'h0);
    apply(mk(1,0,0,1,0,1,1,1,8'h20,36'h0));
    chk("R8 first read after reset masked", 1'b0, 36'h0);
    apply(mk(1,1,0,1,0,1,1,1,8'h00,36'h0));
    chk("R2 load after reset", 1'b1, X);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule